// File: doc/BRIEF.md
# UART FIFO and interrupt unit

This block is the buffering and interrupt half of a high-speed UART. It owns a transmit FIFO that software fills through a data port and a separate serial engine drains, and a receive FIFO that the serial engine fills with bytes tagged for framing errors and breaks, which software drains through the same data port. Four small 32-bit registers and one rate register sit on a word-indexed bus, at byte offsets 0x00 (data), 0x04 (levels), 0x08 (interrupt status), 0x0C (control) and 0x10 (rate). The bus index is `word_addr` = offset / 4.

The block raises one interrupt line. Its sources are programmable FIFO thresholds, an inactivity timeout on the receive side, and sticky error events. The timeout is counted in character times: the serial engine pulses `char_tick` once per character period, and the block counts these pulses while received data waits unread. Bit timing and the rate divider logic are outside this block. The rate register only holds the divider value and presents it to the serial engine.

Top module: `uart_fifo_irq`

## Requirements
- R1: A bus write to index 0 queues `bus_wdata[7:0]` in the transmit FIFO (64 entries). `tx_valid` is high while the FIFO holds data, and `tx_byte` presents the oldest byte. A cycle with `tx_take` high removes that byte. A write to a full transmit FIFO is ignored.
- R2: A read at index 0 removes the oldest receive entry and returns the byte in bits [7:0], the framing tag in bit 9 and the break tag in bit 10. When the receive FIFO is empty, the read returns 0x100 (bit 8 set) and changes nothing.
- R3: Index 1 reads the transmit occupancy in bits [15:8] and the receive occupancy in bits [7:0]. Each FIFO holds at most 64 entries.
- R4: A byte pushed while the receive FIFO holds 64 entries is dropped, and status bit 5 (overrun) is set.
- R5: Writing 1 to status bit 0, 3, 4 or 5 at index 2 clears that bit, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins.
- R6: Status bit 1 is high while the receive occupancy is at least the trigger level. The level is taken from control bits [4:2]: codes 0..5 give 1, 4, 8, 16, 32, 48, and codes 6 and 7 give 48. The bit drops when reads bring the occupancy below the level.
- R7: Status bit 0 is set when a take leaves the transmit occupancy equal to the threshold from control bits [1:0]: codes 0..3 give 0, 4, 8, 16.
- R8: Status bit 2 rises once the receive FIFO has held data for N `char_tick` pulses with no push and no read. N is set by control bits [17:16]: code 0 disables the timeout, and codes 1, 2, 3 give 4, 8, 16. Any push or read restarts the count, and an empty FIFO holds the bit low.
- R9: Accepting a receive entry whose framing tag is set sets status bit 3. Accepting one whose break tag is set sets status bit 4.
- R10: Writing 1 to status bit 6 sets status bit 0. Bit 6 always reads 0.
- R11: `irq` is high when any of these holds: status bit 0 is set with control bit 5 set; status bit 1 or 2 is set with control bit 6 set; status bit 3, 4 or 5 is set with control bit 7 set.
- R12: The control register at index 3 reads back the fields written to it. The rate register at index 4 holds bits [7:0], drives `rate_div`, and resets to 0xFF.
- R13: After reset, both FIFOs are empty, status and control read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_addr | input | 3 | Register index (byte offset / 4) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at index 0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_take | input | 1 | Serial engine consumes `tx_byte` |
| rx_push | input | 1 | Serial engine delivers a received entry |
| rx_byte | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing-error tag for the received byte |
| rx_brk | input | 1 | Break tag for the received byte |
| char_tick | input | 1 | One pulse per character time |
| rate_div | output | 8 | Rate divider value for the serial engine |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is a receive overrun arriving in the same cycle as a software write-one-to-clear of the overrun bit. The bench fills the receive FIFO to 64 entries, then in a single cycle drives `rx_push` and a status write of 0x20. It expects bit 5 to read back set, and then expects a lone clear to reset the bit. A second overlap is a `char_tick` in the same cycle as a push: the push must restart the inactivity count. This is judged by counting exactly four further ticks before status bit 2 rises.

// File: rtl/ufi_pkg.sv
package ufi_pkg;

  localparam int unsigned LVL_W = 8;

  typedef enum logic [2:0] {
    IDX_DATA  = 3'd0,
    IDX_LEVEL = 3'd1,
    IDX_STAT  = 3'd2,
    IDX_CTRL  = 3'd3,
    IDX_RATE  = 3'd4
  } reg_idx_e;

  localparam int unsigned ST_TX   = 0;
  localparam int unsigned ST_TRIG = 1;
  localparam int unsigned ST_TMO  = 2;
  localparam int unsigned ST_FE   = 3;
  localparam int unsigned ST_BRK  = 4;
  localparam int unsigned ST_OVR  = 5;
  localparam int unsigned ST_FRC  = 6;

  typedef struct packed {
    logic [1:0] tmo;
    logic [2:0] ien;
    logic [2:0] rxt;
    logic [1:0] txt;
  } ctrl_t;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic [LVL_W-1:0] rx_level(input logic [2:0] code);
    case (code)
      3'd0:    return LVL_W'(1);
      3'd1:    return LVL_W'(4);
      3'd2:    return LVL_W'(8);
      3'd3:    return LVL_W'(16);
      3'd4:    return LVL_W'(32);
      default: return LVL_W'(48);
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] tx_level(input logic [1:0] code);
    case (code)
      2'd0:    return LVL_W'(0);
      2'd1:    return LVL_W'(4);
      2'd2:    return LVL_W'(8);
      default: return LVL_W'(16);
    endcase
  endfunction

  function automatic logic [4:0] idle_limit(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      2'd3:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/ufi_fifo.sv
module ufi_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign dout  = mem[rd_ptr_q];

  always_comb begin
    push_ok  = push & ~full;
    pop_ok   = pop & ~empty;
    wr_ptr_d = push_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= din;
  end

endmodule

// File: rtl/ufi_idle_timer.sv
module ufi_idle_timer
  import ufi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       waiting,
  input  logic       activity,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       fired
);

  localparam logic [4:0] SAT = 5'd16;

  logic [4:0] cnt_q, cnt_d;
  logic [4:0] limit;

  always_comb begin
    limit = idle_limit(sel);
    if (!waiting || activity)          cnt_d = '0;
    else if (tick && (cnt_q != SAT))   cnt_d = cnt_q + 1'b1;
    else                               cnt_d = cnt_q;
    fired = (sel != 2'd0) && waiting && (cnt_q >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ufi_status.sv
module ufi_status
  import ufi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tx,
  input  logic       ev_fe,
  input  logic       ev_brk,
  input  logic       ev_ovr,
  input  logic       stat_we,
  input  logic [6:0] stat_wmask,
  input  logic       trig_lvl,
  input  logic       tmo_lvl,
  input  logic [2:0] ien,
  output logic [6:0] status,
  output logic       irq
);

  localparam int unsigned NS = 4;

  logic [NS-1:0] set_v, clr_v, st_q, st_d;

  always_comb begin
    set_v = {ev_ovr, ev_brk, ev_fe, ev_tx | (stat_we & stat_wmask[ST_FRC])};
    clr_v = {NS{stat_we}} & {stat_wmask[ST_OVR], stat_wmask[ST_BRK],
                             stat_wmask[ST_FE], stat_wmask[ST_TX]};
  end

  for (genvar i = 0; i < NS; i++) begin : g_sticky
    always_comb begin
      if (set_v[i])      st_d[i] = 1'b1;
      else if (clr_v[i]) st_d[i] = 1'b0;
      else               st_d[i] = st_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= st_d[i];
    end
  end

  always_comb begin
    status = {1'b0, st_q[3], st_q[2], st_q[1], tmo_lvl, trig_lvl, st_q[0]};
    irq    = (status[ST_TX] & ien[0])
           | ((status[ST_TRIG] | status[ST_TMO]) & ien[1])
           | ((status[ST_FE] | status[ST_BRK] | status[ST_OVR]) & ien[2]);
  end

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import ufi_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  word_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  input  logic        tx_take,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  input  logic        char_tick,
  output logic [7:0]  rate_div,
  output logic        irq
);

  localparam int unsigned RXW = $bits(rx_entry_t);

  ctrl_t       ctrl_q, ctrl_d;
  logic [7:0]  rate_q, rate_d;
  logic        ctrl_we, rate_we, stat_we, tx_we, rx_re;

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, tx_push_ok, tx_pop_ok;
  logic          rx_full, rx_empty, rx_push_ok, rx_pop_ok;
  rx_entry_t     rx_in, rx_head;
  logic [RXW-1:0] rx_head_raw;

  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic        ev_tx, ev_fe, ev_brk, ev_ovr;
  logic        trig_lvl, tmo_lvl;
  logic [6:0]  stat_w;
  logic [2:0]  ien_w;
  logic        unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:18], bus_wdata[15:8]};

  // register decode
  always_comb begin
    tx_we   = bus_wr && (word_addr == IDX_DATA);
    stat_we = bus_wr && (word_addr == IDX_STAT);
    ctrl_we = bus_wr && (word_addr == IDX_CTRL);
    rate_we = bus_wr && (word_addr == IDX_RATE);
    rx_re   = bus_rd && (word_addr == IDX_DATA);
    ctrl_d  = ctrl_t'({bus_wdata[17:16], bus_wdata[7:0]});
    rate_d  = bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= 8'hFF;
    else if (rate_we) rate_q <= rate_d;
  end

  assign rate_div = rate_q;
  assign ien_w    = ctrl_q.ien;

  // transmit side
  ufi_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (tx_we),
    .din     (bus_wdata[7:0]),
    .pop     (tx_take),
    .dout    (tx_byte),
    .count   (tx_cnt),
    .full    (tx_full),
    .empty   (tx_empty),
    .push_ok (tx_push_ok),
    .pop_ok  (tx_pop_ok)
  );

  assign tx_valid = ~tx_empty;

  // receive side
  assign rx_in = '{brk: rx_brk, ferr: rx_ferr, data: rx_byte};

  ufi_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (rx_push),
    .din     (rx_in),
    .pop     (rx_re),
    .dout    (rx_head_raw),
    .count   (rx_cnt),
    .full    (rx_full),
    .empty   (rx_empty),
    .push_ok (rx_push_ok),
    .pop_ok  (rx_pop_ok)
  );

  assign rx_head = rx_entry_t'(rx_head_raw);

  ufi_idle_timer u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .waiting  (~rx_empty),
    .activity (rx_push_ok | rx_pop_ok),
    .tick     (char_tick),
    .sel      (ctrl_q.tmo),
    .fired    (tmo_lvl)
  );

  // interrupt events
  always_comb begin
    tx_lvl   = LVL_W'(tx_cnt);
    rx_lvl   = LVL_W'(rx_cnt);
    ev_tx    = tx_pop_ok && !tx_push_ok
               && (tx_lvl == tx_level(ctrl_q.txt) + LVL_W'(1));
    ev_fe    = rx_push_ok && rx_ferr;
    ev_brk   = rx_push_ok && rx_brk;
    ev_ovr   = rx_push && rx_full;
    trig_lvl = (rx_lvl >= rx_level(ctrl_q.rxt));
  end

  ufi_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_tx      (ev_tx),
    .ev_fe      (ev_fe),
    .ev_brk     (ev_brk),
    .ev_ovr     (ev_ovr),
    .stat_we    (stat_we),
    .stat_wmask (bus_wdata[6:0]),
    .trig_lvl   (trig_lvl),
    .tmo_lvl    (tmo_lvl),
    .ien        (ctrl_q.ien),
    .status     (stat_w),
    .irq        (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (word_addr)
      IDX_DATA: begin
        if (rx_empty) bus_rdata[8] = 1'b1;
        else bus_rdata[10:0] = {rx_head.brk, rx_head.ferr, 1'b0, rx_head.data};
      end
      IDX_LEVEL: bus_rdata[15:0] = {tx_lvl, rx_lvl};
      IDX_STAT:  bus_rdata[6:0]  = stat_w;
      IDX_CTRL:  bus_rdata[17:0] = {ctrl_q.tmo, 8'h00, ctrl_q.ien, ctrl_q.rxt, ctrl_q.txt};
      IDX_RATE:  bus_rdata[7:0]  = rate_q;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ufi_checker.sv
module ufi_checker #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    word_addr,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          tx_take,
  input logic          tx_valid,
  input logic          rx_push,
  input logic          irq,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [6:0]    status,
  input logic [2:0]    ien
);

  p_tx_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word_addr == 3'd0 && tx_cnt == CW'(DEPTH) && !tx_take)
      |=> (tx_cnt == CW'(DEPTH)));

  p_tx_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_cnt != '0));

  p_empty_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_addr == 3'd0 && rx_cnt == '0) |-> (bus_rdata[8] && bus_rdata[7:0] == 8'h00));

  p_rx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == CW'(DEPTH)) |=> status[5]);

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word_addr == 3'd2 && bus_wdata[5] && !rx_push) |=> !status[5]);

  p_trig_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |-> !status[1]);

  p_tmo_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt != CW'(DEPTH)) |=> !status[2]);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 3'b000) |-> !irq);

endmodule

bind uart_fifo_irq ufi_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_addr (word_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tx_take   (tx_take),
  .tx_valid  (tx_valid),
  .rx_push   (rx_push),
  .irq       (irq),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt),
  .status    (stat_w),
  .ien       (ien_w)
);

// File: tb/uart_fifo_irq_tb.sv
module uart_fifo_irq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  word_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_byte;
  logic        tx_valid, tx_take;
  logic        rx_push, rx_ferr, rx_brk, char_tick;
  logic [7:0]  rx_byte;
  logic [7:0]  rate_div;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_fifo_irq u_dut (
    .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .char_tick(char_tick), .rate_div(rate_div), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cv(input logic [1:0] txt, input logic [2:0] rxt,
                                     input logic [2:0] en, input logic [1:0] tmo);
    return {14'b0, tmo, 8'b0, en, rxt, txt};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    word_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    word_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic fe, input logic bk);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b; rx_ferr = fe; rx_brk = bk;
    @(negedge clk);
    rx_push = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      char_tick = 1'b1;
      @(negedge clk);
      char_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd1, d); chk("R13 levels", d, 32'h0);
    rd(3'd2, d); chk("R13 status", d, 32'h0);
    rd(3'd3, d); chk("R13 control", d, 32'h0);
    chk("R13 irq", {31'b0, irq}, 32'h0);
    chk("R12 rate reset", {24'b0, rate_div}, 32'hFF);
    rd(3'd0, d); chk("R2 empty read", d, 32'h100);
  endtask

  task automatic t_tx_order();
    logic [31:0] d;
    wr(3'd0, 32'hA1); wr(3'd0, 32'hB2); wr(3'd0, 32'hC3);
    rd(3'd1, d); chk("R3 tx level 3", d, 32'h0300);
    chk("R1 first byte", {23'b0, tx_valid, tx_byte}, 32'h1A1);
    take(); chk("R1 second byte", {23'b0, tx_valid, tx_byte}, 32'h1B2);
    take(); chk("R1 third byte", {23'b0, tx_valid, tx_byte}, 32'h1C3);
    take(); chk("R1 drained", {31'b0, tx_valid}, 32'h0);
    rd(3'd2, d); chk("R7 empty threshold event", d & 32'h1, 32'h1);
    wr(3'd2, 32'h1);
    rd(3'd2, d); chk("R5 w1c tx bit", d & 32'h1, 32'h0);
  endtask

  task automatic t_tx_full();
    logic [31:0] d;
    int bad = 0;
    for (int i = 0; i < 65; i++) wr(3'd0, i);
    rd(3'd1, d); chk("R1 tx full level 64", d, 32'h4000);
    for (int i = 0; i < 64; i++) begin
      if (tx_byte !== 8'(i) || !tx_valid) bad++;
      take();
    end
    chk("R1 order and dropped 65th write", bad, 0);
    chk("R1 empty after 64", {31'b0, tx_valid}, 32'h0);
    wr(3'd2, 32'h1);
    wr(3'd3, cv(2'd2, 3'd0, 3'd0, 2'd0));
    for (int i = 0; i < 10; i++) wr(3'd0, 8'h50 + 8'(i));
    take();
    rd(3'd2, d); chk("R7 at 9 not set", d & 32'h1, 32'h0);
    take();
    rd(3'd2, d); chk("R7 at 8 set", d & 32'h1, 32'h1);
    for (int i = 0; i < 8; i++) take();
    wr(3'd2, 32'h1);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_rx_format();
    logic [31:0] d;
    push(8'h41, 1'b0, 1'b0);
    push(8'h42, 1'b1, 1'b0);
    push(8'h43, 1'b0, 1'b1);
    rd(3'd1, d); chk("R3 rx level 3", d, 32'h0003);
    rd(3'd2, d); chk("R9 fe brk set, R6 trig at 1", d & 32'h1A, 32'h1A);
    rd(3'd0, d); chk("R2 plain byte", d, 32'h041);
    rd(3'd0, d); chk("R2 framing tag", d, 32'h242);
    rd(3'd0, d); chk("R2 break tag", d, 32'h443);
    rd(3'd0, d); chk("R2 empty after drain", d, 32'h100);
    rd(3'd2, d); chk("R6 trig cleared by drain", d & 32'h2, 32'h0);
  endtask

  task automatic t_rx_trig();
    logic [31:0] d;
    wr(3'd3, cv(2'd0, 3'd2, 3'd0, 2'd0));
    for (int i = 0; i < 7; i++) push(8'(i), 1'b0, 1'b0);
    rd(3'd2, d); chk("R6 below 8", d & 32'h2, 32'h0);
    push(8'h07, 1'b0, 1'b0);
    rd(3'd2, d); chk("R6 at 8", d & 32'h2, 32'h2);
    rd(3'd0, d);
    rd(3'd2, d); chk("R6 read drops below", d & 32'h2, 32'h0);
    for (int i = 0; i < 7; i++) rd(3'd0, d);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    int bad = 0;
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R5 write zero keeps fe brk", d & 32'h18, 32'h18);
    wr(3'd2, 32'h18);
    rd(3'd2, d); chk("R5 w1c fe brk", d & 32'h18, 32'h0);
    for (int i = 0; i < 64; i++) push(8'(i), 1'b0, 1'b0);
    push(8'hEE, 1'b0, 1'b0);
    rd(3'd2, d); chk("R4 overrun set", d & 32'h20, 32'h20);
    rd(3'd1, d); chk("R4 level stays 64", d, 32'h0040);
    wr(3'd2, 32'h20);
    rd(3'd2, d); chk("R5 w1c overrun", d & 32'h20, 32'h0);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = 8'hEF;
    word_addr = 3'd2; bus_wdata = 32'h20; bus_wr = 1'b1;
    @(negedge clk);
    rx_push = 1'b0; bus_wr = 1'b0;
    rd(3'd2, d); chk("R5 set wins over clear", d & 32'h20, 32'h20);
    wr(3'd2, 32'h20);
    for (int i = 0; i < 64; i++) begin
      rd(3'd0, d);
      if (d !== 32'(i)) bad++;
    end
    chk("R4 contents kept, extra bytes dropped", bad, 0);
    rd(3'd0, d); chk("R2 empty after overrun drain", d, 32'h100);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    wr(3'd3, cv(2'd0, 3'd5, 3'b010, 2'd1));
    push(8'h11, 1'b0, 1'b0);
    ticks(3);
    rd(3'd2, d); chk("R8 3 ticks no timeout", d & 32'h4, 32'h0);
    ticks(1);
    rd(3'd2, d); chk("R8 4 ticks timeout", d & 32'h4, 32'h4);
    chk("R11 irq from timeout", {31'b0, irq}, 32'h1);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = 8'h22; char_tick = 1'b1;
    @(negedge clk);
    rx_push = 1'b0; char_tick = 1'b0;
    rd(3'd2, d); chk("R8 push restarts", d & 32'h4, 32'h0);
    ticks(3);
    rd(3'd2, d); chk("R8 tick with push not counted", d & 32'h4, 32'h0);
    ticks(1);
    rd(3'd2, d); chk("R8 timeout again", d & 32'h4, 32'h4);
    rd(3'd0, d); chk("R2 first waiting byte", d, 32'h011);
    rd(3'd2, d); chk("R8 read restarts", d & 32'h4, 32'h0);
    rd(3'd0, d);
    ticks(5);
    rd(3'd2, d); chk("R8 empty holds low", d & 32'h4, 32'h0);
    wr(3'd3, cv(2'd0, 3'd5, 3'b000, 2'd0));
    push(8'h33, 1'b0, 1'b0);
    ticks(20);
    rd(3'd2, d); chk("R8 disabled", d & 32'h4, 32'h0);
    wr(3'd3, cv(2'd0, 3'd5, 3'b000, 2'd3));
    rd(3'd0, d); push(8'h44, 1'b0, 1'b0);
    ticks(15);
    rd(3'd2, d); chk("R8 15 of 16", d & 32'h4, 32'h0);
    ticks(1);
    rd(3'd2, d); chk("R8 16 of 16", d & 32'h4, 32'h4);
    rd(3'd0, d);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    push(8'h55, 1'b1, 1'b0);
    chk("R11 no enable no irq", {31'b0, irq}, 32'h0);
    wr(3'd3, cv(2'd0, 3'd5, 3'b100, 2'd0));
    chk("R11 error enable irq", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h08);
    chk("R11 cleared error drops irq", {31'b0, irq}, 32'h0);
    rd(3'd0, d);
    wr(3'd2, 32'h40);
    rd(3'd2, d); chk("R10 force sets tx, bit6 reads 0", d & 32'h41, 32'h01);
    chk("R11 tx source masked", {31'b0, irq}, 32'h0);
    wr(3'd3, cv(2'd0, 3'd5, 3'b001, 2'd0));
    chk("R11 tx enable irq", {31'b0, irq}, 32'h1);
    rd(3'd3, d); chk("R12 control readback", d, cv(2'd0, 3'd5, 3'b001, 2'd0));
    wr(3'd2, 32'h01);
    chk("R11 tx clear drops irq", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_rate();
    logic [31:0] d;
    wr(3'd4, 32'h5A);
    chk("R12 rate output", {24'b0, rate_div}, 32'h5A);
    rd(3'd4, d); chk("R12 rate readback", d, 32'h5A);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; word_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    tx_take = 1'b0; rx_push = 1'b0; rx_byte = '0; rx_ferr = 1'b0; rx_brk = 1'b0;
    char_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx_format();
    t_rx_trig();
    t_overrun();
    t_timeout();
    t_irq();
    t_rate();
    finish_run();
  end

endmodule